// File: doc/BRIEF.md
# Byte-Serial Card Data FIFO Engine

This block moves data between a word FIFO (sixteen 32-bit entries by default) and a card data port that carries a single byte per transfer. A direction bit in the data-control register selects the way the data flows. In receive, bytes from the card are packed into words and pushed into the FIFO. In transmit, words are popped and sent as bytes. A byte down-counter is loaded from a programmed length and runs the transfer. When the counter is spent, the block raises sticky end-of-data events.

The CPU side gets a push/pop port onto the FIFO. It can write words in transmit direction and read words in receive direction. A status vector carries the FIFO level flags, but only for the group that matches the current direction. A word count derived from the byte counter is also exposed. CRC, data timeout, DMA and card line signalling are left to other blocks. The mode and DMA bits are only stored.

Top module: `card_byte_fifo`

## Requirements
- R1: After reset, ctrl_q, byte_cnt, fifo_words and fifo_err are 0, rx_ready and tx_valid are low, and status equals bit 14 plus bit 18 (transmit group, FIFO empty).
- R2: A ctrl_wr pulse stores all 8 bits of ctrl_wdata (bit 0 enable, bit 1 direction with 1 = receive, bit 2 mode, bit 3 DMA enable). When bit 0 of the written value is set, byte_cnt is loaded from the 16-bit length register (written by len_wr) and the byte position restarts at 0. byte_cnt drops by exactly one per card handshake.
- R3: In receive, the first byte of each word lands in bits 7:0, the next in 15:8, and so on. A word is pushed after its fourth byte, or after the byte that takes byte_cnt to 0, with unfilled upper bytes zero.
- R4: rx_ready is high only when enabled, in receive, byte_cnt nonzero, the FIFO not full, and no ctrl_wr in that cycle. A byte is consumed only in a cycle where rx_valid and rx_ready are both high.
- R5: In transmit, tx_byte presents the head word lowest byte first. The head word leaves the FIFO after its fourth byte or after the byte that takes byte_cnt to 0.
- R6: tx_valid is high only when enabled, in transmit, byte_cnt nonzero, the FIFO not empty, and no ctrl_wr in that cycle. rx_ready and tx_valid are never high together.
- R7: status bits 8 and 10 are set in the cycle after any cycle where the enable is set and byte_cnt is 0. They stay set until evt_clr.
- R8: When the enable is set, byte_cnt is 0 and the FIFO is empty, the enable bit clears on the next edge unless ctrl_wr is applied.
- R9: With w words stored, receive direction drives bit 15 (w >= 8), bit 17 (w = 16), bit 19 (w = 0) and bit 21 (w != 0). Transmit drives bit 14 (w <= 8), bit 16 (w = 16), bit 18 (w = 0) and bit 20 (w != 0). The other group reads 0.
- R10: The active bit of the current direction (13 receive, 12 transmit) equals enable AND byte_cnt nonzero.
- R11: fifo_words equals (byte_cnt + 3) >> 2.
- R12: bus_push writes a word only in transmit direction with the FIFO not full. bus_pop removes the head only in receive direction with the FIFO not empty. bus_rdata shows the head word. A push in receive direction and a pop in transmit direction leave the FIFO unchanged.
- R13: fifo_err sets on a bus_push to a full FIFO in transmit direction, or a bus_pop from an empty FIFO in receive direction. It stays set until evt_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the data-control register |
| ctrl_wdata | input | 8 | Data-control value |
| len_wr | input | 1 | Write strobe for the length register |
| len_wdata | input | 16 | Transfer length in bytes |
| evt_clr | input | 1 | Clears the end events and the error flag |
| bus_push | input | 1 | CPU word write into the FIFO |
| bus_wdata | input | 32 | Word to write |
| bus_pop | input | 1 | CPU word read from the FIFO |
| bus_rdata | output | 32 | Head word of the FIFO |
| rx_valid | input | 1 | Card offers a receive byte |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Engine takes the receive byte |
| tx_valid | output | 1 | Engine offers a transmit byte |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Card takes the transmit byte |
| ctrl_q | output | 8 | Data-control register |
| byte_cnt | output | 16 | Remaining bytes |
| fifo_words | output | 15 | Remaining words, rounded up |
| status | output | 22 | End events and direction flag group |
| fifo_err | output | 1 | Sticky CPU overflow/underflow flag |

## Verification
The bench goes after a receive length that is not a multiple of four. A packer that forgot the partial word, or left stale upper bytes in it, would lose or corrupt the tail. It lets the card outrun the CPU until the FIFO fills. An engine that kept accepting bytes would drop data or overwrite the oldest word, and the final contents would disagree. It drives full and empty CPU accesses and accesses in the wrong direction, where a design that honoured them would change the flags, the byte stream or the error bit. A zero length shows whether the end events and the enable clear come out with no handshake at all.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
    localparam int ST_W             = 22;
    localparam int ST_DATA_END      = 8;
    localparam int ST_BLOCK_END     = 10;
    localparam int ST_TX_ACTIVE     = 12;
    localparam int ST_RX_ACTIVE     = 13;
    localparam int ST_TX_HALF_EMPTY = 14;
    localparam int ST_RX_HALF_FULL  = 15;
    localparam int ST_TX_FULL       = 16;
    localparam int ST_RX_FULL       = 17;
    localparam int ST_TX_EMPTY      = 18;
    localparam int ST_RX_EMPTY      = 19;
    localparam int ST_TX_AVAIL      = 20;
    localparam int ST_RX_AVAIL      = 21;

    localparam int CTL_EN     = 0;
    localparam int CTL_DIR_RX = 1;
    localparam int CTL_MODE   = 2;
    localparam int CTL_DMA    = 3;
endpackage

// File: rtl/cbf_word_fifo.sv
module cbf_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic wr_ok, rd_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d     = q;
        wr_ok = wr_en && (q.cnt != CW'(DEPTH));
        rd_ok = rd_en && (q.cnt != '0);
        if (wr_ok) d.wp = ptr_inc(q.wp);
        if (rd_ok) d.rp = ptr_inc(q.rp);
        case ({wr_ok, rd_ok})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[q.wp] <= wr_data;
    end

    assign rd_data = mem[q.rp];
    assign count   = q.cnt;

    assert_count_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + CW'(1)) ||
        (count == $past(count) - CW'(1)));
endmodule

// File: rtl/cbf_flags.sv
module cbf_flags #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic [CW-1:0]           count,
    input  logic                    rx_dir,
    input  logic                    active,
    input  logic                    data_end,
    output logic [cbf_pkg::ST_W-1:0] status
);
    import cbf_pkg::*;

    logic is_empty, is_full, at_most_half, at_least_half;

    always_comb begin
        is_empty      = (count == '0);
        is_full       = (count == CW'(DEPTH));
        at_most_half  = (count <= CW'(HALF));
        at_least_half = (count >= CW'(HALF));
        status = '0;
        status[ST_DATA_END]  = data_end;
        status[ST_BLOCK_END] = data_end;
        if (rx_dir) begin
            status[ST_RX_ACTIVE]    = active;
            status[ST_RX_HALF_FULL] = at_least_half;
            status[ST_RX_FULL]      = is_full;
            status[ST_RX_EMPTY]     = is_empty;
            status[ST_RX_AVAIL]     = !is_empty;
        end else begin
            status[ST_TX_ACTIVE]     = active;
            status[ST_TX_HALF_EMPTY] = at_most_half;
            status[ST_TX_FULL]       = is_full;
            status[ST_TX_EMPTY]      = is_empty;
            status[ST_TX_AVAIL]      = !is_empty;
        end
    end
endmodule

// File: rtl/cbf_engine.sv
module cbf_engine #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int LEN_W = 16,
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int BPW = WIDTH / 8,
    localparam int IW  = (BPW > 1) ? $clog2(BPW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             evt_clr,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_ready,
    input  logic             bus_push,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_pop,
    input  logic [CW-1:0]    fifo_count,
    input  logic [WIDTH-1:0] fifo_head,
    output logic             fifo_wr_en,
    output logic [WIDTH-1:0] fifo_wr_data,
    output logic             fifo_rd_en,
    output logic [7:0]       ctrl_q,
    output logic [LEN_W-1:0] byte_cnt,
    output logic             xfer_active,
    output logic             data_end,
    output logic             fifo_err
);
    import cbf_pkg::*;

    typedef struct packed {
        logic [7:0]       ctrl;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [IW-1:0]    idx;
        logic [WIDTH-1:0] pack;
        logic             dend;
        logic             err;
    } eng_st_t;

    eng_st_t q, d;
    logic rx_mode, run, f_full, f_empty, last_byte, set_end, err_set;
    logic [WIDTH-1:0] merged;

    always_comb begin
        d            = q;
        fifo_wr_en   = 1'b0;
        fifo_wr_data = '0;
        fifo_rd_en   = 1'b0;
        err_set      = 1'b0;
        merged       = '0;
        rx_mode   = q.ctrl[CTL_DIR_RX];
        run       = q.ctrl[CTL_EN] && (q.cnt != '0) && !ctrl_wr;
        f_full    = (fifo_count == CW'(DEPTH));
        f_empty   = (fifo_count == '0);
        rx_ready  = run && rx_mode && !f_full;
        tx_valid  = run && !rx_mode && !f_empty;
        tx_byte   = fifo_head[8 * int'(q.idx) +: 8];
        last_byte = (q.idx == IW'(BPW - 1)) || (q.cnt == LEN_W'(1));
        set_end   = q.ctrl[CTL_EN] && (q.cnt == '0);

        if (rx_ready && rx_valid) begin
            merged = q.pack | (WIDTH'(rx_byte) << (8 * int'(q.idx)));
            d.cnt  = q.cnt - LEN_W'(1);
            if (last_byte) begin
                fifo_wr_en   = 1'b1;
                fifo_wr_data = merged;
                d.pack       = '0;
                d.idx        = '0;
            end else begin
                d.pack = merged;
                d.idx  = q.idx + IW'(1);
            end
        end
        if (tx_valid && tx_ready) begin
            d.cnt = q.cnt - LEN_W'(1);
            if (last_byte) begin
                fifo_rd_en = 1'b1;
                d.idx      = '0;
            end else begin
                d.idx = q.idx + IW'(1);
            end
        end

        if (!rx_mode && bus_push) begin
            if (!f_full) begin
                fifo_wr_en   = 1'b1;
                fifo_wr_data = bus_wdata;
            end else begin
                err_set = 1'b1;
            end
        end
        if (rx_mode && bus_pop) begin
            if (!f_empty) fifo_rd_en = 1'b1;
            else          err_set    = 1'b1;
        end

        if (ctrl_wr) begin
            d.ctrl = ctrl_wdata;
            if (ctrl_wdata[CTL_EN]) begin
                d.cnt  = q.len;
                d.idx  = '0;
                d.pack = '0;
            end
        end else if (set_end && f_empty) begin
            d.ctrl[CTL_EN] = 1'b0;
        end
        if (len_wr) d.len = len_wdata;

        d.dend = (q.dend && !evt_clr) || set_end;
        d.err  = (q.err && !evt_clr) || err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_q      = q.ctrl;
    assign byte_cnt    = q.cnt;
    assign xfer_active = q.ctrl[CTL_EN] && (q.cnt != '0);
    assign data_end    = q.dend;
    assign fifo_err    = q.err;

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_valid && rx_ready) || (tx_valid && tx_ready)) |=>
        (byte_cnt == $past(byte_cnt) - LEN_W'(1)));
    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !(rx_valid && rx_ready) && !(tx_valid && tx_ready)) |=>
        $stable(byte_cnt));
    assert_rx_not_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (fifo_count < CW'(DEPTH)));
    assert_handshake_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ready, tx_valid}));
    assert_en_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl_q[CTL_EN]) && !$past(ctrl_wr)) |->
        ($past(byte_cnt) == '0 && $past(fifo_count) == '0));
    assert_end_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_end && !evt_clr) |=> data_end);
endmodule

// File: rtl/card_byte_fifo.sv
module card_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int LEN_W = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_wr,
    input  logic [7:0]               ctrl_wdata,
    input  logic                     len_wr,
    input  logic [LEN_W-1:0]         len_wdata,
    input  logic                     evt_clr,
    input  logic                     bus_push,
    input  logic [WIDTH-1:0]         bus_wdata,
    input  logic                     bus_pop,
    output logic [WIDTH-1:0]         bus_rdata,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_byte,
    output logic                     rx_ready,
    output logic                     tx_valid,
    output logic [7:0]               tx_byte,
    input  logic                     tx_ready,
    output logic [7:0]               ctrl_q,
    output logic [LEN_W-1:0]         byte_cnt,
    output logic [LEN_W-2:0]         fifo_words,
    output logic [cbf_pkg::ST_W-1:0] status,
    output logic                     fifo_err
);
    logic             fifo_wr_en, fifo_rd_en, xfer_active, data_end;
    logic [WIDTH-1:0] fifo_wr_data, fifo_head;
    logic [CW-1:0]    fifo_count;
    logic [LEN_W:0]   words_sum;

    cbf_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr_en),
        .wr_data (fifo_wr_data),
        .rd_en   (fifo_rd_en),
        .rd_data (fifo_head),
        .count   (fifo_count)
    );

    cbf_engine #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LEN_W(LEN_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .len_wr       (len_wr),
        .len_wdata    (len_wdata),
        .evt_clr      (evt_clr),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_ready     (rx_ready),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte),
        .tx_ready     (tx_ready),
        .bus_push     (bus_push),
        .bus_wdata    (bus_wdata),
        .bus_pop      (bus_pop),
        .fifo_count   (fifo_count),
        .fifo_head    (fifo_head),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data),
        .fifo_rd_en   (fifo_rd_en),
        .ctrl_q       (ctrl_q),
        .byte_cnt     (byte_cnt),
        .xfer_active  (xfer_active),
        .data_end     (data_end),
        .fifo_err     (fifo_err)
    );

    cbf_flags #(.DEPTH(DEPTH)) u_flags (
        .count    (fifo_count),
        .rx_dir   (ctrl_q[cbf_pkg::CTL_DIR_RX]),
        .active   (xfer_active),
        .data_end (data_end),
        .status   (status)
    );

    assign bus_rdata  = fifo_head;
    assign words_sum  = {1'b0, byte_cnt} + (LEN_W + 1)'(3);
    assign fifo_words = words_sum[LEN_W:2];
endmodule

// File: tb/test_card_byte_fifo.sv
module test_card_byte_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0, len_wr = 1'b0, evt_clr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [15:0] len_wdata = '0;
    logic        bus_push = 1'b0, bus_pop = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rx_valid = 1'b0, rx_ready, tx_valid, tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0, tx_byte, ctrl_q;
    logic [15:0] byte_cnt;
    logic [14:0] fifo_words;
    logic [21:0] status;
    logic        fifo_err;

    card_byte_fifo i_card_byte_fifo (.*);

    always #5 clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit chk_on = 0, rx_gaps = 0;

    // reference model state
    logic [7:0]  m_ctrl;
    logic [15:0] m_cnt, m_len;
    logic [31:0] m_q[$];
    int          m_idx;
    logic [31:0] m_pack;
    bit          m_end, m_err, src_pop;
    logic [7:0]  rx_src[$];
    logic [7:0]  got[$];
    int sz;
    bit act, rxm, rdy, tv, set_end, b_push, b_pop, e_err, lastb;

    task automatic chk(string req, logic [31:0] a, logic [31:0] e);
        n_tests++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, a, e);
        end
    endtask

    function automatic logic [21:0] exp_status();
        logic [21:0] s = '0;
        int w = m_q.size();
        bit a = m_ctrl[0] && (m_cnt != 0);
        s[8] = m_end; s[10] = m_end;
        if (m_ctrl[1]) begin
            s[13] = a; s[15] = (w >= 8); s[17] = (w == 16); s[19] = (w == 0); s[21] = (w != 0);
        end else begin
            s[12] = a; s[14] = (w <= 8); s[16] = (w == 16); s[18] = (w == 0); s[20] = (w != 0);
        end
        return s;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = '0; m_len = '0; m_q.delete(); m_idx = 0;
            m_pack = '0; m_end = 0; m_err = 0; src_pop = 0;
        end else begin
            sz      = m_q.size();
            rxm     = m_ctrl[1];
            act     = m_ctrl[0] && (m_cnt != 0) && !ctrl_wr;
            rdy     = act && rxm && (sz < 16);
            tv      = act && !rxm && (sz != 0);
            set_end = m_ctrl[0] && (m_cnt == 0);
            b_push  = bus_push && !rxm && (sz < 16);
            b_pop   = bus_pop && rxm && (sz != 0);
            e_err   = (bus_push && !rxm && sz == 16) || (bus_pop && rxm && sz == 0);
            src_pop = rdy && rx_valid;
            lastb   = (m_idx == 3) || (m_cnt == 1);
            if (b_pop) void'(m_q.pop_front());
            if (tv && tx_ready) begin
                got.push_back(tx_byte);
                if (lastb) begin void'(m_q.pop_front()); m_idx = 0; end
                else m_idx++;
                m_cnt--;
            end
            if (src_pop) begin
                m_pack = m_pack | (32'(rx_byte) << (8 * m_idx));
                if (lastb) begin m_q.push_back(m_pack); m_pack = '0; m_idx = 0; end
                else m_idx++;
                m_cnt--;
            end
            if (b_push) m_q.push_back(bus_wdata);
            if (ctrl_wr) begin
                m_ctrl = ctrl_wdata;
                if (ctrl_wdata[0]) begin m_cnt = m_len; m_idx = 0; m_pack = '0; end
            end else if (set_end && sz == 0) m_ctrl[0] = 1'b0;
            if (len_wr) m_len = len_wdata;
            m_end = (m_end && !evt_clr) || set_end;
            m_err = (m_err && !evt_clr) || e_err;
        end
    end

    // card side driver
    always @(negedge clk) begin
        #1;
        if (src_pop && rx_src.size() > 0) void'(rx_src.pop_front());
        rx_valid = (rx_src.size() > 0) && (!rx_gaps || (cyc % 3 != 1));
        rx_byte  = (rx_src.size() > 0) ? rx_src[0] : 8'h00;
        tx_ready = (cyc % 4 != 2);
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            logic [21:0] es;
            logic [31:0] hd;
            bit er, et;
            es = exp_status();
            er = m_ctrl[0] && m_cnt != 0 && !ctrl_wr && m_ctrl[1] && m_q.size() < 16;
            et = m_ctrl[0] && m_cnt != 0 && !ctrl_wr && !m_ctrl[1] && m_q.size() != 0;
            chk("R2 ctrl_q", 32'(ctrl_q), 32'(m_ctrl));
            chk("R2 byte_cnt", 32'(byte_cnt), 32'(m_cnt));
            chk("R11 fifo_words", 32'(fifo_words), (32'(m_cnt) + 3) >> 2);
            chk("R4 rx_ready", 32'(rx_ready), 32'(er));
            chk("R6 tx_valid", 32'(tx_valid), 32'(et));
            if (et) begin
                hd = m_q[0];
                chk("R5 tx_byte", 32'(tx_byte), 32'(hd[8*m_idx +: 8]));
            end
            if (m_q.size() > 0) chk("R12 bus_rdata", bus_rdata, m_q[0]);
            chk("R7 end bits", 32'({status[10], status[8]}), 32'({es[10], es[8]}));
            chk("R10 active", 32'({status[13], status[12]}), 32'({es[13], es[12]}));
            chk("R9 flags", 32'(status & 22'h3FC000), 32'(es & 22'h3FC000));
            chk("R13 fifo_err", 32'(fifo_err), 32'(m_err));
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask
    task automatic wr_ctrl(logic [7:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1; step(); ctrl_wr = 1'b0;
    endtask
    task automatic wr_len(logic [15:0] v);
        len_wdata = v; len_wr = 1'b1; step(); len_wr = 1'b0;
    endtask
    task automatic clr();
        evt_clr = 1'b1; step(); evt_clr = 1'b0;
    endtask
    task automatic push(logic [31:0] v);
        bus_wdata = v; bus_push = 1'b1; step(); bus_push = 1'b0;
    endtask
    task automatic pop_expect(string req, logic [31:0] e);
        int k = 0;
        while (!status[21] && k < 200) begin step(); k++; end
        chk(req, bus_rdata, e);
        bus_pop = 1'b1; step(); bus_pop = 1'b0;
    endtask
    task automatic wait_done(string req);
        int k = 0;
        while (byte_cnt != 0 && k < 2000) begin step(); k++; end
        chk(req, 32'(byte_cnt), 32'd0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 ctrl_q", 32'(ctrl_q), 0);
        chk("R1 byte_cnt", 32'(byte_cnt), 0);
        chk("R1 fifo_words", 32'(fifo_words), 0);
        chk("R1 status", 32'(status), 32'h0004_4000);
        chk("R1 fifo_err", 32'(fifo_err), 0);
        chk("R1 handshakes", 32'({rx_ready, tx_valid}), 0);
        chk_on = 1;

        // receive, length not a multiple of four
        rx_gaps = 1;
        for (int i = 0; i < 6; i++) rx_src.push_back(8'h11 + 8'(i));
        wr_len(16'd6);
        wr_ctrl(8'h03);
        chk("R2 load", 32'(byte_cnt), 6);
        chk("R11 words", 32'(fifo_words), 2);
        wait_done("R4 rx drained");
        step(2);
        chk("R7 data end", 32'({status[10], status[8]}), 32'h3);
        pop_expect("R3 full word", 32'h1413_1211);
        pop_expect("R3 partial word", 32'h0000_1615);
        step(3);
        chk("R8 enable cleared", 32'(ctrl_q), 32'h02);
        clr();
        step();
        chk("R7 cleared", 32'({status[10], status[8]}), 0);

        // receive outruns the CPU
        rx_gaps = 0;
        for (int i = 0; i < 80; i++) rx_src.push_back(8'(i + 32));
        wr_len(16'd80);
        wr_ctrl(8'h03);
        step(90);
        chk("R4 stall count", 32'(byte_cnt), 16);
        chk("R9 rx full", 32'(status[17]), 1);
        chk("R4 rx_ready low", 32'(rx_ready), 0);
        for (int j = 0; j < 20; j++) begin
            logic [31:0] w;
            for (int b = 0; b < 4; b++) w[8*b +: 8] = 8'(4*j + b + 32);
            pop_expect("R3 packed", w);
        end
        step(3);
        bus_pop = 1'b1; step(); bus_pop = 1'b0;
        chk("R13 pop empty", 32'(fifo_err), 1);
        clr();
        chk("R13 cleared", 32'(fifo_err), 0);

        // transmit
        wr_ctrl(8'h00);
        push(32'hA3A2_A1A0); push(32'hB3B2_B1B0); push(32'hC3C2_C1C0);
        chk("R9 tx flags", 32'(status), 32'h0010_4000);
        bus_pop = 1'b1; step(); bus_pop = 1'b0;
        chk("R12 pop ignored", 32'(status), 32'h0010_4000);
        chk("R12 no err", 32'(fifo_err), 0);
        got.delete();
        wr_len(16'd10);
        wr_ctrl(8'h01);
        wait_done("R6 tx drained");
        step(3);
        chk("R5 tx count", got.size(), 10);
        for (int i = 0; i < 10; i++) begin
            logic [7:0] e;
            e = (i < 4) ? 8'hA0 + 8'(i) : (i < 8) ? 8'hB0 + 8'(i - 4) : 8'hC0 + 8'(i - 8);
            chk("R5 tx order", 32'(got[i]), 32'(e));
        end
        chk("R8 tx enable cleared", 32'(ctrl_q), 0);
        chk("R7 tx end", 32'(status), 32'h0004_4500);
        clr();

        // full FIFO and wraparound
        for (int j = 0; j < 16; j++) push(32'h1000_0000 + 32'h0101_0101 * j);
        chk("R9 tx full", 32'(status[16]), 1);
        push(32'hFFFF_FFFF);
        chk("R13 push full", 32'(fifo_err), 1);
        clr();
        got.delete();
        wr_len(16'd64);
        wr_ctrl(8'h01);
        wait_done("R5 wrap drained");
        step(3);
        for (int i = 0; i < 64; i++) begin
            logic [31:0] w;
            w = 32'h1000_0000 + 32'h0101_0101 * (i / 4);
            chk("R5 wrap bytes", 32'(got[i]), 32'(w[8*(i%4) +: 8]));
        end
        clr();

        // push in receive direction ignored
        wr_ctrl(8'h02);
        push(32'hDEAD_BEEF);
        step();
        chk("R12 push ignored", 32'(status), 32'h0008_0000);
        chk("R12 push no err", 32'(fifo_err), 0);

        // mode bits stored, zero length
        wr_ctrl(8'h0C);
        chk("R2 ctrl stored", 32'(ctrl_q), 32'h0C);
        wr_len(16'd0);
        wr_ctrl(8'h0D);
        chk("R2 zero load", 32'(byte_cnt), 0);
        step(2);
        chk("R7 zero length end", 32'({status[10], status[8]}), 32'h3);
        chk("R8 zero length clear", 32'(ctrl_q), 32'h0C);
        step(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule